// File: doc/BRIEF.md
# Compressed-Mode Length and Mode Tracker

This block sits at the front of an instruction decoder for a core that mixes a base 32-bit instruction set with a 16-bit compressed encoding. Each cycle it looks at the oldest instruction parcel in the fetch window. It decides whether that instruction is 16 or 32 bits long and which decode mode applies to it: base, 10-bit compressed or 16-bit compressed. It also keeps the mode state that will govern the following instruction. The fetch side offers a 32-bit window whose upper half is the oldest parcel. It raises a separate flag when the lower half also holds valid data. The block answers combinationally with a take strobe and the consumed length, so fetch can advance.

The decision uses only three pieces of the first parcel. Bits are numbered from 0 at the most significant end. The first piece is a compressed entry tag, set when bits 0 to 4 are all zero. The other two are the in-band bits N (bit 0) and M (bit 15). A major/minor field in bits 5 to 8 is also checked, to spot one group of parcels where bit 0 is an operand. The result is registered once and handed to the full decoder. That decoder cannot revise a length or mode that has already been sent. A context port exposes the held mode state and lets trap entry and return save and reload it.

Top module: `csm_tracker`

## Requirements
- R1: A synchronous reset clears the held state to base mode (context code 0) and drives `o_valid` low.
- R2: In base mode, a parcel whose bits 0 to 4 are not all zero is taken as a 32-bit instruction reported with mode code 0 (base), and the held state stays base.
- R3: In base mode, a parcel whose bits 0 to 4 are all zero is taken as a 16-bit instruction with mode code 1 (10-bit). If M (bit 15, the least significant bit) is 0 the next state is base; if it is 1 the next state is 16-bit compressed (context code 1).
- R4: In 16-bit compressed state, each parcel is a 16-bit instruction with mode code 2. N (bit 0, the most significant bit) and M together pick the next state: {N,M}=00 gives base, while 01 and 11 both give 16-bit compressed.
- R5: In 16-bit compressed state, {N,M}=10 enters a one-shot state (context code 2). There, exactly one 32-bit instruction is taken with mode code 0, whatever its top bits hold, and the state then returns to 16-bit compressed.
- R6: In 16-bit compressed state, a parcel whose bits 5 to 8 equal 0011 ignores N: M=0 gives base and M=1 gives 16-bit compressed.
- R7: An instruction that needs 32 bits is taken only when `pcl_word_ok` is high. Otherwise `pcl_take` stays low and the held state is unchanged. `pcl_take_len32` is high exactly when a 32-bit instruction is taken.
- R8: The cycle after a take, `o_valid` is high and `o_len32`, `o_mode` and `o_insn` describe that instruction. A 16-bit instruction appears in the upper half of `o_insn` with the lower half zero. With no take in a cycle, `o_valid` is low in the next.
- R9: `ctx_state` always shows the held state. A `ctx_wr` pulse loads `ctx_wr_state`, where code 3 loads base. Nothing is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pcl_valid | input | 1 | Upper half of the fetch window holds a parcel |
| pcl_word_ok | input | 1 | Lower half of the fetch window is also valid |
| pcl_data | input | 32 | Fetch window; bits 31:16 are the oldest parcel |
| pcl_take | output | 1 | Instruction consumed this cycle |
| pcl_take_len32 | output | 1 | Consumed instruction is 32 bits |
| ctx_state | output | 2 | Held mode state (0 base, 1 16-bit, 2 one-shot) |
| ctx_wr | input | 1 | Load the held state from ctx_wr_state |
| ctx_wr_state | input | 2 | State code to restore |
| o_valid | output | 1 | Registered decision is valid |
| o_len32 | output | 1 | Registered instruction length is 32 bits |
| o_mode | output | 2 | Registered decode mode (0 base, 1 10-bit, 2 16-bit) |
| o_insn | output | 32 | Registered instruction bits |

## Verification
The bench aims at the one-shot path. This includes a stall while the one-shot state waits for a full word, and a one-shot word whose top five bits are zero. A tracker that looked for the entry tag there would report a 16-bit 10-bit-form instruction and drop out of compressed mode. The bench drives a 16-bit parcel with bits 5 to 8 at 0011 and N set. A design that treated N as a mode bit there would fall into the one-shot state instead of base. It issues context writes while a valid parcel is present, including the unused code 3. A wrong design would consume an instruction during the restore or be left in an undefined state. Stalls on a missing lower half must leave both the state and the output strobe quiet.

// File: rtl/csm_pkg.sv
package csm_pkg;

    localparam int PARCEL_W = 16;
    localparam int WORD_W   = 2 * PARCEL_W;
    localparam int TAG_W    = 5;
    localparam int OPF_W    = 4;
    // bits 5..8 counted from the MSB of the parcel
    localparam int OPF_MSB  = PARCEL_W - 1 - 5;
    localparam int CTX_W    = 2;
    localparam logic [OPF_W-1:0] OPF_M_ONLY = 4'b0011;

    typedef enum logic [CTX_W-1:0] {
        ST_BASE = 2'd0,
        ST_C16  = 2'd1,
        ST_ONCE = 2'd2
    } mstate_e;

    typedef enum logic [1:0] {
        DM_BASE = 2'd0,
        DM_C10  = 2'd1,
        DM_C16  = 2'd2
    } dmode_e;

    typedef struct packed {
        logic tag;
        logic n;
        logic m;
        logic m_only;
    } pfields_t;

    typedef struct packed {
        logic    len32;
        dmode_e  mode;
        mstate_e nxt;
    } decision_t;

    function automatic mstate_e ctx_decode(input logic [CTX_W-1:0] c);
        mstate_e s;
        case (c)
            2'd1:    s = ST_C16;
            2'd2:    s = ST_ONCE;
            default: s = ST_BASE;
        endcase
        return s;
    endfunction

    function automatic pfields_t split_parcel(input logic [PARCEL_W-1:0] p);
        pfields_t f;
        f.tag    = (p[PARCEL_W-1 -: TAG_W] == '0);
        f.n      = p[PARCEL_W-1];
        f.m      = p[0];
        f.m_only = (p[OPF_MSB -: OPF_W] == OPF_M_ONLY);
        return f;
    endfunction

    function automatic mstate_e c16_next(input logic n, input logic m, input logic m_only);
        mstate_e s;
        if (m_only) begin
            s = m ? ST_C16 : ST_BASE;
        end else begin
            case ({n, m})
                2'b00:   s = ST_BASE;
                2'b10:   s = ST_ONCE;
                default: s = ST_C16;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/csm_classify.sv
module csm_classify
    import csm_pkg::*;
(
    input  logic [PARCEL_W-1:0] parcel,
    output pfields_t            fields
);
    always_comb begin
        fields = split_parcel(parcel);
    end
endmodule

// File: rtl/csm_decide.sv
module csm_decide
    import csm_pkg::*;
(
    input  mstate_e   cur,
    input  pfields_t  fields,
    output decision_t dec
);
    always_comb begin
        dec.len32 = 1'b0;
        dec.mode  = DM_BASE;
        dec.nxt   = ST_BASE;
        unique case (cur)
            ST_BASE: begin
                if (fields.tag) begin
                    dec.len32 = 1'b0;
                    dec.mode  = DM_C10;
                    dec.nxt   = fields.m ? ST_C16 : ST_BASE;
                end else begin
                    dec.len32 = 1'b1;
                    dec.mode  = DM_BASE;
                    dec.nxt   = ST_BASE;
                end
            end
            ST_C16: begin
                dec.len32 = 1'b0;
                dec.mode  = DM_C16;
                dec.nxt   = c16_next(fields.n, fields.m, fields.m_only);
            end
            ST_ONCE: begin
                dec.len32 = 1'b1;
                dec.mode  = DM_BASE;
                dec.nxt   = ST_C16;
            end
            default: begin
                dec.len32 = 1'b0;
                dec.mode  = DM_BASE;
                dec.nxt   = ST_BASE;
            end
        endcase
    end
endmodule

// File: rtl/csm_state.sv
module csm_state
    import csm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  mstate_e          nxt,
    input  logic             wr,
    input  logic [CTX_W-1:0] wr_code,
    output mstate_e          cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= ST_BASE;
        end else if (wr) begin
            cur <= ctx_decode(wr_code);
        end else if (adv) begin
            cur <= nxt;
        end
    end

    // R1: reset lands in base mode
    p_reset_base_r1: assert property (@(posedge clk) rst |=> cur == ST_BASE);

    // R5: one-shot state lasts exactly one accepted instruction
    p_once_returns_r5: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_ONCE && adv && !wr) |=> cur == ST_C16);

    // R7: without advance or write the state holds
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!adv && !wr) |=> $stable(cur));

    // R9: restore loads the requested state
    p_restore_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && wr_code == 2'd1) |=> cur == ST_C16);
endmodule

// File: rtl/csm_outstage.sv
module csm_outstage
    import csm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  decision_t         dec,
    input  logic [WORD_W-1:0] word,
    output logic              o_valid,
    output logic              o_len32,
    output logic [1:0]        o_mode,
    output logic [WORD_W-1:0] o_insn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_len32 <= 1'b0;
            o_mode  <= DM_BASE;
            o_insn  <= '0;
        end else begin
            o_valid <= take;
            if (take) begin
                o_len32 <= dec.len32;
                o_mode  <= dec.mode;
                o_insn  <= dec.len32 ? word : {word[WORD_W-1 -: PARCEL_W], {PARCEL_W{1'b0}}};
            end
        end
    end

    // R8: output strobe follows the take one cycle later
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        take |=> o_valid);
    p_idle_follows_r8: assert property (@(posedge clk) disable iff (rst)
        !take |=> !o_valid);

    // R4: a 16-bit compressed decision is never 32 bits long
    p_c16_short_r4: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_mode == DM_C16) |-> !o_len32);

    // R8: short instructions carry a zero lower half
    p_short_pad_r8: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_len32) |-> (o_insn[PARCEL_W-1:0] == '0));
endmodule

// File: rtl/csm_tracker.sv
module csm_tracker
    import csm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pcl_valid,
    input  logic        pcl_word_ok,
    input  logic [31:0] pcl_data,
    output logic        pcl_take,
    output logic        pcl_take_len32,
    output logic [1:0]  ctx_state,
    input  logic        ctx_wr,
    input  logic [1:0]  ctx_wr_state,
    output logic        o_valid,
    output logic        o_len32,
    output logic [1:0]  o_mode,
    output logic [31:0] o_insn
);
    pfields_t  fields;
    decision_t dec;
    mstate_e   cur;

    csm_classify u_classify (
        .parcel (pcl_data[WORD_W-1 -: PARCEL_W]),
        .fields (fields)
    );

    csm_decide u_decide (
        .cur    (cur),
        .fields (fields),
        .dec    (dec)
    );

    always_comb begin
        pcl_take       = pcl_valid && !ctx_wr && (!dec.len32 || pcl_word_ok);
        pcl_take_len32 = pcl_take && dec.len32;
        ctx_state      = cur;
    end

    csm_state u_state (
        .clk     (clk),
        .rst     (rst),
        .adv     (pcl_take),
        .nxt     (dec.nxt),
        .wr      (ctx_wr),
        .wr_code (ctx_wr_state),
        .cur     (cur)
    );

    csm_outstage u_out (
        .clk     (clk),
        .rst     (rst),
        .take    (pcl_take),
        .dec     (dec),
        .word    (pcl_data),
        .o_valid (o_valid),
        .o_len32 (o_len32),
        .o_mode  (o_mode),
        .o_insn  (o_insn)
    );

    // R7: a 32-bit instruction is never taken without a full word
    p_no_half_word_r7: assert property (@(posedge clk) disable iff (rst)
        (pcl_take_len32) |-> pcl_word_ok);

    // R9: no instruction consumed while restoring context
    p_wr_blocks_take_r9: assert property (@(posedge clk) disable iff (rst)
        ctx_wr |-> !pcl_take);

    // R3: tagged parcel in base mode reports the 10-bit form next cycle
    p_tag_c10_r3: assert property (@(posedge clk) disable iff (rst)
        (pcl_take && cur == ST_BASE && pcl_data[31:27] == 5'd0) |=> (o_mode == DM_C10 && !o_len32));
endmodule

// File: tb/test_csm_tracker.sv
`timescale 1ns/1ps
module test_csm_tracker;
    logic        clk = 1'b0;
    logic        rst;
    logic        pcl_valid, pcl_word_ok, ctx_wr;
    logic [31:0] pcl_data;
    logic [1:0]  ctx_wr_state;
    logic        pcl_take, pcl_take_len32, o_valid, o_len32;
    logic [1:0]  ctx_state, o_mode;
    logic [31:0] o_insn;

    int n_chk = 0;
    int n_fail = 0;
    int m_st = 0;   // model: 0 base, 1 16-bit, 2 one-shot
    bit done = 0;

    always #2 clk = ~clk;

    csm_tracker i_csm_tracker (
        .clk(clk), .rst(rst), .pcl_valid(pcl_valid), .pcl_word_ok(pcl_word_ok),
        .pcl_data(pcl_data), .pcl_take(pcl_take), .pcl_take_len32(pcl_take_len32),
        .ctx_state(ctx_state), .ctx_wr(ctx_wr), .ctx_wr_state(ctx_wr_state),
        .o_valid(o_valid), .o_len32(o_len32), .o_mode(o_mode), .o_insn(o_insn)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference of the mode rules
    task automatic model(input int st, input logic [31:0] d,
                         output int len32, output int md, output int nx);
        logic [15:0] p;
        int nm;
        p = d[31:16];
        nm = {30'd0, p[15], p[0]};
        if (st == 2) begin
            len32 = 1; md = 0; nx = 1;
        end else if (st == 0) begin
            if (p[15:11] == 5'd0) begin
                len32 = 0; md = 1; nx = p[0] ? 1 : 0;
            end else begin
                len32 = 1; md = 0; nx = 0;
            end
        end else begin
            len32 = 0; md = 2;
            if (p[10:7] == 4'b0011) nx = p[0] ? 1 : 0;
            else if (nm == 0) nx = 0;
            else if (nm == 2) nx = 2;
            else nx = 1;
        end
    endtask

    task automatic step(input string tag, input logic v, input logic wok,
                        input logic [31:0] d, input logic wr, input logic [1:0] wv);
        int len32, md, nx, tk;
        pcl_valid = v; pcl_word_ok = wok; pcl_data = d;
        ctx_wr = wr; ctx_wr_state = wv;
        model(m_st, d, len32, md, nx);
        tk = (v && !wr && (len32 == 0 || wok)) ? 1 : 0;
        #1;
        chk("R7 take", {31'd0, pcl_take}, tk);
        chk("R7 take_len32", {31'd0, pcl_take_len32}, (tk != 0 && len32 != 0) ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 o_valid", {31'd0, o_valid}, tk);
        if (tk != 0) begin
            chk({tag, " len32"}, {31'd0, o_len32}, len32);
            chk({tag, " mode"}, {30'd0, o_mode}, md);
            chk("R8 insn", o_insn, (len32 != 0) ? d : {d[31:16], 16'h0000});
            m_st = nx;
        end
        if (wr) m_st = (wv == 2'd1) ? 1 : (wv == 2'd2) ? 2 : 0;
        chk({tag, " state"}, {30'd0, ctx_state}, m_st);
        pcl_valid = 1'b0; ctx_wr = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pcl_valid = 0; pcl_word_ok = 0; pcl_data = '0;
        ctx_wr = 0; ctx_wr_state = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 o_valid", {31'd0, o_valid}, 0);
        chk("R1 state", {30'd0, ctx_state}, 0);

        step("R2", 1, 1, 32'h7C00_1234, 0, 0);   // plain base word
        step("R7", 1, 0, 32'h7C00_0000, 0, 0);   // base word, lower half missing
        step("R3", 1, 1, 32'h0100_ABCD, 0, 0);   // tagged, M=0
        step("R3", 1, 0, 32'h0101_0000, 0, 0);   // tagged, M=1 -> 16-bit
        step("R4", 1, 0, 32'h4001_0000, 0, 0);   // 01 stays
        step("R4", 1, 0, 32'h8001_0000, 0, 0);   // 11 stays
        step("R6", 1, 0, 32'h8180_0000, 0, 0);   // 0011 field, N=1 M=0 -> base
        step("R3", 1, 0, 32'h0001_0000, 0, 0);   // back to 16-bit
        step("R6", 1, 0, 32'h0181_0000, 0, 0);   // 0011 field, M=1 -> stay
        step("R5", 1, 0, 32'h8000_0000, 0, 0);   // 10 -> one-shot
        step("R7", 1, 0, 32'h0000_1234, 0, 0);   // one-shot stalls w/o word
        step("R5", 1, 1, 32'h0000_1234, 0, 0);   // tagged-looking word taken as 32
        step("R4", 0, 1, 32'h4000_0000, 0, 0);   // no valid, nothing taken
        step("R4", 1, 0, 32'h4000_0000, 0, 0);   // 00 -> base
        step("R9", 1, 1, 32'h0000_0000, 1, 2'd2);// restore one-shot, no take
        step("R5", 1, 1, 32'h1234_5678, 0, 0);
        step("R9", 1, 0, 32'h4000_0000, 1, 2'd3);// code 3 -> base
        step("R9", 0, 0, 32'h0, 1, 2'd1);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] d;
            logic        w;
            d = $urandom;
            if ($urandom_range(1, 0) == 1) d[31:27] = 5'd0;
            if ($urandom_range(3, 0) == 0) d[26:23] = 4'b0011;
            w = ($urandom_range(3, 0) != 0);
            if ($urandom_range(19, 0) == 0)
                step("R9", 1, w, d, 1, 2'($urandom_range(3, 0)));
            else
                step("R4", ($urandom_range(7, 0) != 0), w, d, 0, 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule